// File: doc/BRIEF.md
# TDM Timeslot Access and Strobe Unit

This block sits on a serial time-division frame bus that carries twelve byte-wide timeslots per frame on two data lines, one running upstream and one downstream. The bus advances one bit per clock. A rising edge on the frame-sync input marks bit 0 of slot 0. Four byte registers, which a host can read and write, can each be bound to any slot and to either line. This lets the host capture a slot, loop a slot back, shift a byte from one slot into another, or simply monitor traffic. Two strobe outputs mark chosen slots for external devices.

Each access register carries a small commit stage between its capture shifter and its visible data. A byte captured in slot a becomes visible to outputs from slot a+2 onwards. This yields a fixed rule for whether a shifted byte leaves in the same frame or the next one. A register that is not driving releases its line to all ones, and all drivers are merged as a wired AND. Per-register transfer and overflow flags, each with its own mask, feed a single interrupt output.

The frame timer runs a two-state machine. HUNT waits for sync. FRAME_START moves HUNT to RUN on a sync rise. RESYNC restarts the count inside RUN on a new sync rise. FRAME_END returns RUN to HUNT after bit 95. Each access register runs IDLE/HELD. CAPTURE moves IDLE to HELD when a byte completes in a slot other than 11. COMMIT returns HELD to IDLE at the next slot boundary. DIRECT writes a byte captured in slot 11 straight into the data register, with no HELD step.

Top module: `tdm_slot_access`

## Requirements
- R1: After reset the four data registers (addresses 0..3) read 0xFF, the configuration registers (4..7) and strobe registers (10, 11) read 0x00, the mask register (9) reads 0xFF, the flag register (8) reads 0x00, both line outputs are 1, strobes are 0 and irq is 0.
- R2: Slot number equals bit position since the sync rise divided by 8, with bytes sent MSB first. While no frame is running (before the first sync, or after bit 95 until the next sync rise), both line outputs stay 1 and both strobes stay 0.
- R3: With configuration bits [3:0]=slot s, bit 4 (port)=0, bit 5 (capture enable)=1 and bit 6 (drive enable)=1, the byte received upstream in slot s is driven downstream in slot s of the next frame.
- R4: When bit 7 (shift) is set on register 1 or 3, that register drives the data of register 0 or 2 respectively. If the partner captures in slot a and the driver uses slot b with b >= a+2, the byte leaves in the same frame.
- R5: In the same setup with b < a+2 (including a=11, b=0), the byte leaves in the next frame and the current frame carries the earlier value.
- R6: A register with drive enabled drives its stored value, either 0xFF from reset or the last host write, when nothing has been captured.
- R7: Port bit 1 captures from the downstream input and drives the upstream output. With capture enabled and drive disabled, the captured byte is readable at the register's data address while both lines stay released.
- R8: When a frame reaches bit 0 of a register's slot and either of its enables is set, its transfer flag (register 8, bit r) is set. irq is high while any unmasked flag is set, and writing 1 to a flag bit at address 8 clears it.
- R9: If the transfer flag is still set when the slot is reached again, the overflow flag (register 8, bit 4+r) is set.
- R10: Mask bit r (address 9) stops transfer flag r from setting, and mask bit 4+r stops overflow flag r from setting. A masked source raises no irq.
- R11: Strobe register layout is [3:0] slot t, bit 4 enables slot t, bit 5 enables slot t+1. The strobe is high for the whole of each enabled slot, and slot t+1 does not exist for t=11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bus bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; rising edge marks bit 0 of slot 0 |
| up_in | input | 1 | Upstream line receive data |
| dn_in | input | 1 | Downstream line receive data |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| up_out | output | 1 | Upstream line drive, 1 when released |
| dn_out | output | 1 | Downstream line drive, 1 when released |
| stb | output | 2 | Slot strobes |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the slot-commit boundary. It shifts into b=a+2, b=a+1 and from slot 11 into slot 0. A design that made captured data visible one slot too early would send the new byte at a+1. One that committed late would hold back a=11 data for an extra frame. It checks that a looped byte appears only a frame later, and that the first looped frame carries 0xFF, which a design without a defined reset value would corrupt. Overflow, flag clearing and masking are checked across repeated frames without acknowledge. Strobe spans are checked at slot 11, where a wrapping design would also fire at slot 0. Random configurations and traffic are then compared slot by slot against a bench model.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int NSLOT      = 12;
    localparam int SLOT_BITS  = 8;
    localparam int NREG       = 4;
    localparam int NSTB       = 2;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = SLOT_BITS;
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int FRAME_BITS = NSLOT * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS + 1);

    localparam int ADR_DATA0 = 0;
    localparam int ADR_CFG0  = ADR_DATA0 + NREG;
    localparam int ADR_FLAG  = ADR_CFG0 + NREG;
    localparam int ADR_MASK  = ADR_FLAG + 1;
    localparam int ADR_STB0  = ADR_MASK + 1;

    typedef struct packed {
        logic              shift;
        logic              en_out;
        logic              en_in;
        logic              port;
        logic [SLOT_W-1:0] slot;
    } acc_cfg_t;

    typedef struct packed {
        logic [1:0]        spare;
        logic              en_next;
        logic              en_first;
        logic [SLOT_W-1:0] slot;
    } stb_cfg_t;

    typedef enum logic {TMR_HUNT, TMR_RUN} tmr_state_t;
    typedef enum logic {ACC_IDLE, ACC_HELD} acc_state_t;
endpackage

// File: rtl/tsa_frame_timer.sv
module tsa_frame_timer
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bitn,
    output logic              slot_end
);
    tmr_state_t       state_q, state_d;
    logic             fs_q;
    logic             fs_rise;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;

    assign fs_rise = fsync & ~fs_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_HUNT: if (fs_rise) state_d = TMR_RUN;
            TMR_RUN:  if (!fs_rise && pos_q == POS_W'(FRAME_BITS - 1)) state_d = TMR_HUNT;
            default:  state_d = TMR_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_HUNT;
            fs_q    <= 1'b0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            fs_q    <= fsync;
            if (fs_rise)
                pos_q <= POS_W'(1);
            else if (state_q == TMR_RUN)
                pos_q <= pos_q + POS_W'(1);
            else
                pos_q <= '0;
        end
    end

    always_comb begin
        cur_pos  = fs_rise ? '0 : pos_q;
        active   = fs_rise | (state_q == TMR_RUN);
        slot     = cur_pos[BIT_W +: SLOT_W];
        bitn     = cur_pos[BIT_W-1:0];
        slot_end = active && (bitn == '1);
    end
endmodule

// File: rtl/tsa_access_reg.sv
module tsa_access_reg
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BIT_W-1:0]  bitn,
    input  logic              slot_end,
    input  acc_cfg_t          cfg,
    input  logic              up_in,
    input  logic              dn_in,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] src_byte,
    output logic [DATA_W-1:0] data_q,
    output logic              drv_up,
    output logic              drv_dn,
    output logic              hit
);
    acc_state_t        st_q, st_d;
    logic [DATA_W-1:0] sh_q, pend_q, cap_byte;
    logic              in_bit, in_slot, cap_done, last_slot;
    logic              out_on, out_bit;
    logic [BIT_W-1:0]  idx;

    always_comb begin
        in_bit    = cfg.port ? dn_in : up_in;
        in_slot   = active && (slot == cfg.slot) && cfg.en_in;
        cap_done  = in_slot && slot_end;
        cap_byte  = {sh_q[DATA_W-2:0], in_bit};
        last_slot = (slot == SLOT_W'(NSLOT - 1));
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE: if (cap_done && !last_slot) st_d = ACC_HELD;
            ACC_HELD: if (slot_end) st_d = (cap_done && !last_slot) ? ACC_HELD : ACC_IDLE;
            default:  st_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ACC_IDLE;
            sh_q   <= '1;
            pend_q <= '1;
            data_q <= '1;
        end else begin
            st_q <= st_d;
            if (in_slot)
                sh_q <= cap_byte;
            if (cap_done && !last_slot)
                pend_q <= cap_byte;
            if (st_q == ACC_HELD && slot_end)
                data_q <= pend_q;
            if (cap_done && last_slot)
                data_q <= cap_byte;
            if (wr_data)
                data_q <= wdata;
        end
    end

    always_comb begin
        out_on  = active && (slot == cfg.slot) && cfg.en_out;
        idx     = BIT_W'(SLOT_BITS - 1) - bitn;
        out_bit = src_byte[idx];
        drv_dn  = !(out_on && !cfg.port) || out_bit;
        drv_up  = !(out_on && cfg.port) || out_bit;
        hit     = active && (bitn == '0) && (slot == cfg.slot) && (cfg.en_in || cfg.en_out);
    end
endmodule

// File: rtl/tsa_strobe_gen.sv
module tsa_strobe_gen
    import tsa_pkg::*;
(
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    input  stb_cfg_t          cfg,
    output logic              strobe
);
    logic [SLOT_W:0] next_slot;
    logic            on_first, on_next;

    always_comb begin
        next_slot = {1'b0, cfg.slot} + (SLOT_W+1)'(1);
        on_first  = cfg.en_first && (slot == cfg.slot);
        on_next   = cfg.en_next && ({1'b0, slot} == next_slot);
        strobe    = active && (on_first || on_next);
    end
endmodule

// File: rtl/tsa_irq_ctrl.sv
module tsa_irq_ctrl
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   hit,
    input  logic [2*NREG-1:0] mask,
    input  logic              ack_wr,
    input  logic [2*NREG-1:0] ack,
    output logic [NREG-1:0]   sti_q,
    output logic [NREG-1:0]   stov_q,
    output logic              irq
);
    logic [NREG-1:0] set_sti, set_ov, clr_sti, clr_ov;

    always_comb begin
        set_sti = hit & ~mask[NREG-1:0];
        set_ov  = set_sti & sti_q & ~mask[2*NREG-1:NREG];
        clr_sti = ack_wr ? ack[NREG-1:0] : '0;
        clr_ov  = ack_wr ? ack[2*NREG-1:NREG] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sti_q  <= '0;
            stov_q <= '0;
        end else begin
            sti_q  <= (sti_q & ~clr_sti) | set_sti;
            stov_q <= (stov_q & ~clr_ov) | set_ov;
        end
    end

    assign irq = |((sti_q & ~mask[NREG-1:0]) | (stov_q & ~mask[2*NREG-1:NREG]));
endmodule

// File: rtl/tdm_slot_access.sv
module tdm_slot_access
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              up_in,
    input  logic              dn_in,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              up_out,
    output logic              dn_out,
    output logic [NSTB-1:0]   stb,
    output logic              irq
);
    logic              active, slot_end;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitn;

    acc_cfg_t          cfg_q    [NREG];
    stb_cfg_t          stbc_q   [NSTB];
    logic [2*NREG-1:0] mask_q;
    logic [DATA_W-1:0] data_q   [NREG];
    logic [DATA_W-1:0] src_byte [NREG];
    logic [NREG-1:0]   wr_data, drv_up, drv_dn, hit;
    logic [NREG-1:0]   sti_q, stov_q;
    logic              ack_wr;

    tsa_frame_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .active   (active),
        .slot     (slot),
        .bitn     (bitn),
        .slot_end (slot_end)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) cfg_q[r] <= '0;
            for (int k = 0; k < NSTB; k++) stbc_q[k] <= '0;
            mask_q <= '1;
        end else if (host_wr) begin
            for (int r = 0; r < NREG; r++)
                if (host_addr == ADDR_W'(ADR_CFG0 + r)) cfg_q[r] <= acc_cfg_t'(host_wdata);
            for (int k = 0; k < NSTB; k++)
                if (host_addr == ADDR_W'(ADR_STB0 + k)) stbc_q[k] <= stb_cfg_t'(host_wdata);
            if (host_addr == ADDR_W'(ADR_MASK)) mask_q <= host_wdata;
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_acc
        assign wr_data[r] = host_wr && (host_addr == ADDR_W'(ADR_DATA0 + r));
        if (r % 2 == 1) begin : g_odd
            assign src_byte[r] = cfg_q[r].shift ? data_q[r-1] : data_q[r];
        end else begin : g_even
            assign src_byte[r] = data_q[r];
        end
        tsa_access_reg u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active),
            .slot     (slot),
            .bitn     (bitn),
            .slot_end (slot_end),
            .cfg      (cfg_q[r]),
            .up_in    (up_in),
            .dn_in    (dn_in),
            .wr_data  (wr_data[r]),
            .wdata    (host_wdata),
            .src_byte (src_byte[r]),
            .data_q   (data_q[r]),
            .drv_up   (drv_up[r]),
            .drv_dn   (drv_dn[r]),
            .hit      (hit[r])
        );
    end

    for (genvar k = 0; k < NSTB; k++) begin : g_stb
        tsa_strobe_gen u_stb (
            .active (active),
            .slot   (slot),
            .cfg    (stbc_q[k]),
            .strobe (stb[k])
        );
    end

    assign ack_wr = host_wr && (host_addr == ADDR_W'(ADR_FLAG));

    tsa_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .mask   (mask_q),
        .ack_wr (ack_wr),
        .ack    (host_wdata),
        .sti_q  (sti_q),
        .stov_q (stov_q),
        .irq    (irq)
    );

    assign up_out = &drv_up;
    assign dn_out = &drv_dn;

    always_comb begin
        host_rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (host_addr == ADDR_W'(ADR_DATA0 + r)) host_rdata = data_q[r];
            if (host_addr == ADDR_W'(ADR_CFG0 + r))  host_rdata = DATA_W'(cfg_q[r]);
        end
        for (int k = 0; k < NSTB; k++)
            if (host_addr == ADDR_W'(ADR_STB0 + k)) host_rdata = DATA_W'(stbc_q[k]);
        if (host_addr == ADDR_W'(ADR_FLAG)) host_rdata = DATA_W'({stov_q, sti_q});
        if (host_addr == ADDR_W'(ADR_MASK)) host_rdata = DATA_W'(mask_q);
    end
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker
    import tsa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              active,
    input logic [SLOT_W-1:0] slot,
    input logic              up_out,
    input logic              dn_out,
    input logic [NSTB-1:0]   stb,
    input logic [NREG-1:0]   sti,
    input logic [NREG-1:0]   stov,
    input logic [2*NREG-1:0] mask
);
    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (up_out && dn_out && stb == '0));

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (slot < SLOT_W'(NSLOT)));

    // R9
    ov_needs_sti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stov & ~$past(stov)) & ~$past(sti)) == '0);

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sti & ~$past(sti)) & $past(mask[NREG-1:0])) == '0);

    // R10
    masked_ov_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stov & ~$past(stov)) & $past(mask[2*NREG-1:NREG])) == '0);
endmodule

bind tdm_slot_access tsa_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .slot   (slot),
    .up_out (up_out),
    .dn_out (dn_out),
    .stb    (stb),
    .sti    (sti_q),
    .stov   (stov_q),
    .mask   (mask_q)
);

// File: tb/tdm_slot_access_bench.sv
module tdm_slot_access_bench;
    import tsa_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n, fsync, up_in, dn_in, host_wr;
    logic [3:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       up_out, dn_out, irq;
    logic [1:0] stb;

    always #2 clk = ~clk;

    tdm_slot_access u_tdm_slot_access (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .up_in(up_in), .dn_in(dn_in),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .up_out(up_out), .dn_out(dn_out), .stb(stb), .irq(irq)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] fr_up [12], fr_dn [12];
    logic [7:0] obs_dn [12], obs_up [12], exp_dn [12], exp_up [12];
    logic [7:0] obs_s [2][12], exp_s [2][12];
    logic [7:0] m_data [4], m_pend [4], m_cfg [4], m_stb [2];
    bit         m_pv [4];
    logic [7:0] m_mask;
    logic [3:0] m_sti, m_stov;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (a < 4) m_data[a] = d;
        else if (a < 8) m_cfg[a-4] = d;
        else if (a == 8) begin m_sti &= ~d[3:0]; m_stov &= ~d[7:4]; end
        else if (a == 9) m_mask = d;
        else if (a < 12) m_stb[a-10] = d;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic lines_idle();
        for (int s = 0; s < 12; s++) begin fr_up[s] = 8'hFF; fr_dn[s] = 8'hFF; end
    endtask

    task automatic model_frame();
        for (int s = 0; s < 12; s++) begin
            exp_dn[s] = 8'hFF; exp_up[s] = 8'hFF;
            for (int r = 0; r < 4; r++) begin
                logic [7:0] c;
                logic [7:0] src;
                c = m_cfg[r];
                if (int'(c[3:0]) == s && c[6]) begin
                    src = m_data[r];
                    if (r % 2 == 1 && c[7]) src = m_data[r-1];
                    if (!c[4]) exp_dn[s] &= src; else exp_up[s] &= src;
                end
                if (int'(c[3:0]) == s && (c[5] || c[6]) && !m_mask[r]) begin
                    if (m_sti[r] && !m_mask[4+r]) m_stov[r] = 1'b1;
                    m_sti[r] = 1'b1;
                end
            end
            for (int k = 0; k < 2; k++) begin
                bit on;
                on = (m_stb[k][4] && int'(m_stb[k][3:0]) == s) ||
                     (m_stb[k][5] && int'(m_stb[k][3:0]) + 1 == s);
                exp_s[k][s] = on ? 8'hFF : 8'h00;
            end
            for (int r = 0; r < 4; r++) begin
                logic [7:0] c;
                logic [7:0] b;
                c = m_cfg[r];
                if (m_pv[r]) begin m_data[r] = m_pend[r]; m_pv[r] = 1'b0; end
                if (int'(c[3:0]) == s && c[5]) begin
                    b = c[4] ? fr_dn[s] : fr_up[s];
                    if (s == 11) m_data[r] = b;
                    else begin m_pend[r] = b; m_pv[r] = 1'b1; end
                end
            end
        end
    endtask

    task automatic drive_frame();
        for (int p = 0; p < 96; p++) begin
            @(negedge clk);
            fsync = (p == 0);
            up_in = fr_up[p/8][7 - p%8];
            dn_in = fr_dn[p/8][7 - p%8];
            #1;
            obs_dn[p/8][7 - p%8] = dn_out;
            obs_up[p/8][7 - p%8] = up_out;
            obs_s[0][p/8][7 - p%8] = stb[0];
            obs_s[1][p/8][7 - p%8] = stb[1];
        end
        @(negedge clk);
        fsync = 1'b0; up_in = 1'b1; dn_in = 1'b1;
    endtask

    task automatic frame(string req);
        logic [7:0] d;
        model_frame();
        drive_frame();
        for (int s = 0; s < 12; s++) begin
            check({req, " dn"}, obs_dn[s], exp_dn[s]);
            check({req, " up"}, obs_up[s], exp_up[s]);
            check({req, " R11 stb0"}, obs_s[0][s], exp_s[0][s]);
            check({req, " R11 stb1"}, obs_s[1][s], exp_s[1][s]);
        end
        bus_read(4'd8, d);
        check({req, " R8 R9 flags"}, d, {m_stov, m_sti});
        check({req, " R8 irq"}, irq,
              |((m_sti & ~m_mask[3:0]) | (m_stov & ~m_mask[7:4])));
    endtask

    initial begin
        #(4 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       all_one;
        void'($urandom(32'd7341));
        rst_n = 1'b0; fsync = 1'b0; up_in = 1'b1; dn_in = 1'b1;
        host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        for (int r = 0; r < 4; r++) begin
            m_data[r] = 8'hFF; m_pend[r] = 8'hFF; m_cfg[r] = 8'h00; m_pv[r] = 1'b0;
        end
        m_stb[0] = 8'h00; m_stb[1] = 8'h00; m_mask = 8'hFF; m_sti = '0; m_stov = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 12; a++) begin
            bus_read(4'(a), d);
            check("R1 reset reg", d, (a < 4 || a == 9) ? 8'hFF : 8'h00);
        end
        check("R1 reset lines", {up_out, dn_out, stb, irq}, 5'b11000);

        // R2 no frame: lines released even with drive enabled
        bus_write(4'd4, 8'h40);
        all_one = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); up_in = i[0]; #1 all_one &= dn_out & up_out;
        end
        check("R2 idle released", all_one, 1'b1);

        // R6 then R3 loop on slot 3
        bus_write(4'd4, 8'h63);
        lines_idle(); fr_up[3] = 8'hA5;
        frame("R6 R2");
        check("R6 first loop frame drives reset value", obs_dn[3], 8'hFF);
        lines_idle(); fr_up[3] = 8'h3C;
        frame("R3");
        check("R3 looped byte next frame", obs_dn[3], 8'hA5);

        // R4 shift 2 -> 4 same frame
        bus_write(4'd4, 8'h22);
        bus_write(4'd5, 8'hC4);
        lines_idle(); fr_up[2] = 8'h5A;
        frame("R4");
        check("R4 shift b=a+2 same frame", obs_dn[4], 8'h5A);

        // R5 shift 2 -> 3 next frame
        bus_write(4'd5, 8'hC3);
        lines_idle(); fr_up[2] = 8'h77;
        frame("R5");
        check("R5 shift b=a+1 old byte", obs_dn[3], 8'h5A);
        lines_idle(); fr_up[2] = 8'h11;
        frame("R5");
        check("R5 shift b=a+1 next frame", obs_dn[3], 8'h77);

        // R5 shift 11 -> 0
        bus_write(4'd4, 8'h2B);
        bus_write(4'd5, 8'hC0);
        lines_idle(); fr_up[11] = 8'hE1;
        frame("R5");
        check("R5 shift a=11 b=0 old byte", obs_dn[0], 8'h11);
        lines_idle();
        frame("R5");
        check("R5 shift a=11 b=0 next frame", obs_dn[0], 8'hE1);

        // R7 monitor downstream, drive upstream from host data
        bus_write(4'd6, 8'h36);
        bus_write(4'd3, 8'h12);
        bus_write(4'd7, 8'h57);
        lines_idle(); fr_dn[6] = 8'hC3;
        frame("R7");
        bus_read(4'd2, d);
        check("R7 monitored byte", d, 8'hC3);
        check("R7 monitor leaves upstream slot 6", obs_up[6], 8'hFF);
        check("R6 R7 host byte on upstream", obs_up[7], 8'h12);

        // R8 R9 R10 interrupts
        bus_write(4'd9, 8'h00);
        lines_idle();
        frame("R8");
        check("R8 irq raised", irq, 1'b1);
        frame("R9");
        bus_read(4'd8, d);
        check("R9 overflow set", d[7:4], 4'hF);
        bus_write(4'd8, 8'hFF);
        bus_read(4'd8, d);
        check("R8 ack clears", d, 8'h00);
        check("R8 irq cleared", irq, 1'b0);
        bus_write(4'd9, 8'h11);
        frame("R10");
        bus_read(4'd8, d);
        check("R10 masked flag stays clear", d[0], 1'b0);

        // R11 strobes
        bus_write(4'd10, 8'h35);
        bus_write(4'd11, 8'h3B);
        lines_idle();
        frame("R11");
        check("R11 stb0 slot t+1", obs_s[0][6], 8'hFF);
        check("R11 stb1 no wrap", obs_s[1][0], 8'h00);
        check("R11 stb1 slot 11", obs_s[1][11], 8'hFF);

        // random mix
        for (int f = 0; f < 40; f++) begin
            for (int k = 0; k < 3; k++) begin
                int kind;
                int r;
                kind = int'($urandom % 5);
                r = int'($urandom % 4);
                case (kind)
                    0: bus_write(4'(r), 8'($urandom));
                    1: bus_write(4'(4 + r), {3'($urandom), 1'($urandom), 4'($urandom % 13)});
                    2: bus_write(4'd9, 8'($urandom));
                    3: bus_write(4'd8, 8'($urandom));
                    default: bus_write(4'(10 + r % 2), {2'b00, 2'($urandom), 4'($urandom % 12)});
                endcase
            end
            for (int s = 0; s < 12; s++) begin
                fr_up[s] = 8'($urandom);
                fr_dn[s] = 8'($urandom);
            end
            frame("R3 R4 R5 R7 R9 R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule